// File: doc/BRIEF.md
# DRAM Power-Down Entry Scheduler

This block sits in the command path of a DRAM controller and decides the earliest cycle in which the clock-enable pin may be driven low to start power-down. It watches every command the controller issues, including its bank and whether the burst length is fixed to chop-4 by the mode register. For each class of command it keeps a countdown of the minimum wait that must pass before clock enable may fall. The read and write waits are computed from read latency, write latency and write recovery, which are configuration inputs given in clock cycles.

The controller holds `pd_req` high to ask for power-down. When no countdown is pending and no command is issued in that cycle, the block drops `cke` in the next cycle. In that same cycle it pulses `pd_grant`, and the command path must send a no-operation or deselect. `pd_active` tells whether the entry is active power-down (a bank is still open) or precharge power-down (all banks closed). When `pd_req` is released, `cke` returns high. The exit timing itself belongs to other logic.

Top module: `pd_entry_sched`

## Requirements
- R1: After a synchronous reset, `cke` is 1, `pd_grant` is 0 and `pd_active` is 0.
- R2: An entry is decided only in a cycle where `pd_req` is 1, `cmd_valid` is 0, `cke` is 1 and no wait is pending. `cke` is 0 from the next cycle on, and `pd_grant` is 1 for exactly that first low cycle. A command in the deciding cycle postpones the entry.
- R3: Command codes are: activate 1, precharge 2, precharge-all 3, refresh 8. After any of these, the first cycle with `cke` low lies at least 1 cycle after the command cycle.
- R4: For read (code 4) and read with auto-precharge (code 5), the first `cke`-low cycle lies at least `cfg_rl`+5 cycles after the command.
- R5: For write (code 6), the first `cke`-low cycle lies at least `cfg_wl`+4+`cfg_wr` cycles after the command. If `cmd_bc4_fixed` is 1, the 4 becomes 2.
- R6: For write with auto-precharge (code 7), the wait is `cfg_wl`+4+`cfg_wr`+1 cycles, with 2 in place of 4 when `cmd_bc4_fixed` is 1.
- R7: After a mode-register set (code 9), the wait is `cfg_tmod` cycles. After a ZQ calibration (code 10), the wait is `cfg_tzq` cycles.
- R8: Several pending waits combine: the entry comes at the latest of all their deadlines, and a later short command never shortens a pending longer wait.
- R9: Activate opens its bank. Precharge, read with auto-precharge and write with auto-precharge close their bank, and precharge-all closes every bank. At the grant, `pd_active` becomes 1 if any bank is open and 0 if all are closed.
- R10: While `pd_req` stays 1, `cke` stays 0 and `pd_active` holds. The cycle after `pd_req` is seen at 0, `cke` is 1 again.
- R11: A command presented while `cke` is 0 is ignored: it opens no bank, closes no bank and starts no wait.
- R12: Codes 0 and 11 to 15 start no wait and leave the bank state unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| cmd_valid | input | 1 | A command is issued in this cycle |
| cmd_code | input | 4 | Command code (see requirements) |
| cmd_bank | input | BANK_W | Target bank of the command |
| cmd_bc4_fixed | input | 1 | Chop-4 fixed by the mode register for this write |
| cfg_rl | input | CFG_W | Read latency in cycles |
| cfg_wl | input | CFG_W | Write latency in cycles |
| cfg_wr | input | CFG_W | Write recovery in cycles |
| cfg_tmod | input | CFG_W | Mode-register-set to entry wait in cycles |
| cfg_tzq | input | CFG_W | ZQ calibration busy time in cycles |
| pd_req | input | 1 | Level request to enter power-down |
| cke | output | 1 | Clock enable to the DRAM |
| pd_grant | output | 1 | One-cycle pulse in the first low cycle of `cke` |
| pd_active | output | 1 | 1 for active power-down, 0 for precharge power-down |

## Verification
The in-line assertions check the following on every cycle. Each countdown decrements by one when no command reloads it. A reload never leaves a countdown below the new requirement. A falling `cke` always comes with a grant, and the grant lasts only one cycle and only follows a cycle in which all countdowns read zero. Precharge-all clears the bank state. Commands presented while `cke` is low leave the banks untouched, and `pd_active` holds throughout power-down. Only the bench scenarios can show that each command's wait formula, with or without fixed chop-4, lands the entry on exactly the right cycle. The same goes for the rule that the longest of overlapping waits wins, and for the active or precharge result after realistic sequences of opening and closing banks.

// File: rtl/pd_entry_pkg.sv
package pd_entry_pkg;

  localparam logic [3:0] CMD_ACT  = 4'd1;
  localparam logic [3:0] CMD_PRE  = 4'd2;
  localparam logic [3:0] CMD_PREA = 4'd3;
  localparam logic [3:0] CMD_RD   = 4'd4;
  localparam logic [3:0] CMD_RDA  = 4'd5;
  localparam logic [3:0] CMD_WR   = 4'd6;
  localparam logic [3:0] CMD_WRA  = 4'd7;
  localparam logic [3:0] CMD_REF  = 4'd8;
  localparam logic [3:0] CMD_MRS  = 4'd9;
  localparam logic [3:0] CMD_ZQC  = 4'd10;

  // wait classes, one countdown each
  localparam int NUM_CLS   = 4;
  localparam int CLS_SHORT = 0;
  localparam int CLS_READ  = 1;
  localparam int CLS_WRITE = 2;
  localparam int CLS_CFG   = 3;

endpackage

// File: rtl/pd_delay_calc.sv
module pd_delay_calc
  import pd_entry_pkg::*;
#(
  parameter int CFG_W = 6,
  parameter int CNT_W = 9
) (
  input  logic                            cmd_en,
  input  logic [3:0]                      cmd_code,
  input  logic                            bc4_fixed,
  input  logic [CFG_W-1:0]                cfg_rl,
  input  logic [CFG_W-1:0]                cfg_wl,
  input  logic [CFG_W-1:0]                cfg_wr,
  input  logic [CFG_W-1:0]                cfg_tmod,
  input  logic [CFG_W-1:0]                cfg_tzq,
  output logic [NUM_CLS-1:0]              ld,
  output logic [NUM_CLS-1:0][CNT_W-1:0]   ld_val
);

  localparam int PAD = CNT_W - CFG_W;

  logic [CNT_W-1:0] rl_x, wl_x, wr_x, tmod_x, tzq_x;
  logic [CNT_W-1:0] burst_x;
  logic [CNT_W-1:0] dly;
  logic [CNT_W-1:0] dly_m2;
  logic [1:0]       cls;
  logic             hit;

  assign rl_x    = {{PAD{1'b0}}, cfg_rl};
  assign wl_x    = {{PAD{1'b0}}, cfg_wl};
  assign wr_x    = {{PAD{1'b0}}, cfg_wr};
  assign tmod_x  = {{PAD{1'b0}}, cfg_tmod};
  assign tzq_x   = {{PAD{1'b0}}, cfg_tzq};
  assign burst_x = bc4_fixed ? CNT_W'(2) : CNT_W'(4);

  always_comb begin
    hit = 1'b1;
    cls = 2'(CLS_SHORT);
    dly = '0;
    case (cmd_code)
      CMD_ACT, CMD_PRE, CMD_PREA, CMD_REF: begin
        cls = 2'(CLS_SHORT);
        dly = CNT_W'(1);
      end
      CMD_RD, CMD_RDA: begin
        cls = 2'(CLS_READ);
        dly = rl_x + CNT_W'(5);
      end
      CMD_WR: begin
        cls = 2'(CLS_WRITE);
        dly = wl_x + burst_x + wr_x;
      end
      CMD_WRA: begin
        cls = 2'(CLS_WRITE);
        dly = wl_x + burst_x + wr_x + CNT_W'(1);
      end
      CMD_MRS: begin
        cls = 2'(CLS_CFG);
        dly = tmod_x;
      end
      CMD_ZQC: begin
        cls = 2'(CLS_CFG);
        dly = tzq_x;
      end
      default: hit = 1'b0;
    endcase
  end

  // the countdown is seen one cycle after the command, and the entry
  // decision leads the low cke cycle by one: remove two, floor at zero
  assign dly_m2 = (dly > CNT_W'(2)) ? dly - CNT_W'(2) : '0;

  always_comb begin
    ld     = '0;
    ld_val = '0;
    if (cmd_en && hit) begin
      ld[cls]     = 1'b1;
      ld_val[cls] = dly_m2;
    end
  end

endmodule

// File: rtl/pd_countdown.sv
module pd_countdown #(
  parameter int W = 9
) (
  input  logic         clk,
  input  logic         rst,
  input  logic         ld,
  input  logic [W-1:0] ld_val,
  output logic [W-1:0] cnt,
  output logic         zero
);

  logic [W-1:0] dec;

  assign dec  = (cnt == '0) ? '0 : cnt - W'(1);
  assign zero = (cnt == '0);

  always_ff @(posedge clk) begin
    if (rst) begin
      cnt <= '0;
    end else if (ld) begin
      cnt <= (dec > ld_val) ? dec : ld_val;
    end else begin
      cnt <= dec;
    end
  end

  // R8: an idle countdown steps down by exactly one
  p_count_step_r8: assert property (@(posedge clk) disable iff (rst)
    (!ld && cnt != '0) |=> (cnt == W'($past(cnt) - W'(1))));

  // R8: a reload never undercuts the new requirement
  p_reload_keeps_max_r8: assert property (@(posedge clk) disable iff (rst)
    ld |=> (cnt >= $past(ld_val)));

endmodule

// File: rtl/pd_bank_track.sv
module pd_bank_track
  import pd_entry_pkg::*;
#(
  parameter int BANKS  = 8,
  parameter int BANK_W = 3
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              en,
  input  logic [3:0]        cmd_code,
  input  logic [BANK_W-1:0] cmd_bank,
  output logic [BANKS-1:0]  open_vec
);

  logic close_all;
  assign close_all = en && (cmd_code == CMD_PREA);

  for (genvar b = 0; b < BANKS; b++) begin : g_bank
    logic sel;
    logic do_open;
    logic do_close;

    assign sel      = en && (cmd_bank == BANK_W'(b));
    assign do_open  = sel && (cmd_code == CMD_ACT);
    assign do_close = sel && ((cmd_code == CMD_PRE) || (cmd_code == CMD_RDA) ||
                              (cmd_code == CMD_WRA));

    always_ff @(posedge clk) begin
      if (rst || close_all || do_close) begin
        open_vec[b] <= 1'b0;
      end else if (do_open) begin
        open_vec[b] <= 1'b1;
      end
    end
  end

  // R9: precharge-all leaves every bank closed
  p_close_all_r9: assert property (@(posedge clk) disable iff (rst)
    close_all |=> (open_vec == '0));

endmodule

// File: rtl/pd_entry_sched.sv
module pd_entry_sched
  import pd_entry_pkg::*;
#(
  parameter int CFG_W  = 6,
  parameter int BANKS  = 8,
  parameter int BANK_W = $clog2(BANKS)
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              cmd_valid,
  input  logic [3:0]        cmd_code,
  input  logic [BANK_W-1:0] cmd_bank,
  input  logic              cmd_bc4_fixed,
  input  logic [CFG_W-1:0]  cfg_rl,
  input  logic [CFG_W-1:0]  cfg_wl,
  input  logic [CFG_W-1:0]  cfg_wr,
  input  logic [CFG_W-1:0]  cfg_tmod,
  input  logic [CFG_W-1:0]  cfg_tzq,
  input  logic              pd_req,
  output logic              cke,
  output logic              pd_grant,
  output logic              pd_active
);

  // largest wait is wl + 4 + wr + 1, fits in CFG_W + 2 bits; one spare
  localparam int CNT_W = CFG_W + 3;

  logic                          cmd_en;
  logic [NUM_CLS-1:0]            ld;
  logic [NUM_CLS-1:0][CNT_W-1:0] ld_val;
  logic [NUM_CLS-1:0][CNT_W-1:0] cnt_vec;
  logic [NUM_CLS-1:0]            zero_vec;
  logic                          all_zero;
  logic [BANKS-1:0]              open_vec;
  logic                          go;
  logic                          cke_q, grant_q, act_q;

  // commands only count while the device is awake
  assign cmd_en = cmd_valid && cke_q;

  pd_delay_calc #(
    .CFG_W (CFG_W),
    .CNT_W (CNT_W)
  ) u_calc (
    .cmd_en    (cmd_en),
    .cmd_code  (cmd_code),
    .bc4_fixed (cmd_bc4_fixed),
    .cfg_rl    (cfg_rl),
    .cfg_wl    (cfg_wl),
    .cfg_wr    (cfg_wr),
    .cfg_tmod  (cfg_tmod),
    .cfg_tzq   (cfg_tzq),
    .ld        (ld),
    .ld_val    (ld_val)
  );

  for (genvar g = 0; g < NUM_CLS; g++) begin : g_cd
    pd_countdown #(
      .W (CNT_W)
    ) u_cd (
      .clk    (clk),
      .rst    (rst),
      .ld     (ld[g]),
      .ld_val (ld_val[g]),
      .cnt    (cnt_vec[g]),
      .zero   (zero_vec[g])
    );
  end

  assign all_zero = &zero_vec;

  pd_bank_track #(
    .BANKS  (BANKS),
    .BANK_W (BANK_W)
  ) u_banks (
    .clk      (clk),
    .rst      (rst),
    .en       (cmd_en),
    .cmd_code (cmd_code),
    .cmd_bank (cmd_bank),
    .open_vec (open_vec)
  );

  assign go = cke_q && pd_req && !cmd_valid && all_zero;

  always_ff @(posedge clk) begin
    if (rst) begin
      cke_q   <= 1'b1;
      grant_q <= 1'b0;
      act_q   <= 1'b0;
    end else begin
      grant_q <= 1'b0;
      if (cke_q) begin
        if (go) begin
          cke_q   <= 1'b0;
          grant_q <= 1'b1;
          act_q   <= |open_vec;
        end
      end else if (!pd_req) begin
        cke_q <= 1'b1;
      end
    end
  end

  assign cke       = cke_q;
  assign pd_grant  = grant_q;
  assign pd_active = act_q;

  // R2: clock enable only falls together with a grant
  p_fall_with_grant_r2: assert property (@(posedge clk) disable iff (rst)
    $fell(cke) |-> pd_grant);

  // R2: the grant is a single-cycle pulse
  p_grant_pulse_r2: assert property (@(posedge clk) disable iff (rst)
    pd_grant |=> !pd_grant);

  // R8: a grant follows a cycle in which no countdown was pending
  p_grant_clear_r8: assert property (@(posedge clk) disable iff (rst)
    pd_grant |-> $past(all_zero));

  // R10: the entry kind holds while powered down
  p_kind_hold_r10: assert property (@(posedge clk) disable iff (rst)
    (!cke && $past(!cke)) |-> $stable(pd_active));

  // R11: commands during power-down leave the bank state alone
  p_ignore_banks_r11: assert property (@(posedge clk) disable iff (rst)
    (!cke && cmd_valid) |=> $stable(open_vec));

endmodule

// File: tb/pd_entry_sched_tb_top.sv
module pd_entry_sched_tb_top;

  localparam int CFG_W  = 6;
  localparam int BANKS  = 8;
  localparam int BANK_W = 3;

  localparam int RL   = 11;
  localparam int WL   = 8;
  localparam int WRC  = 12;
  localparam int TMOD = 12;
  localparam int TZQ  = 40;

  logic              clk = 1'b0;
  logic              rst = 1'b1;
  logic              cmd_valid = 1'b0;
  logic [3:0]        cmd_code = '0;
  logic [BANK_W-1:0] cmd_bank = '0;
  logic              cmd_bc4 = 1'b0;
  logic              pd_req = 1'b0;
  logic              cke, pd_grant, pd_active;

  int    checks = 0;
  int    errors = 0;
  int    cyc = 0;
  bit    done = 1'b0;
  string cur_req = "R1";

  // behavioural reference state
  int         m_earliest;
  bit [7:0]   m_open;
  bit         m_cke, m_grant, m_act;

  always #2 clk = ~clk;

  pd_entry_sched #(
    .CFG_W  (CFG_W),
    .BANKS  (BANKS),
    .BANK_W (BANK_W)
  ) dut_i (
    .clk           (clk),
    .rst           (rst),
    .cmd_valid     (cmd_valid),
    .cmd_code      (cmd_code),
    .cmd_bank      (cmd_bank),
    .cmd_bc4_fixed (cmd_bc4),
    .cfg_rl        (CFG_W'(RL)),
    .cfg_wl        (CFG_W'(WL)),
    .cfg_wr        (CFG_W'(WRC)),
    .cfg_tmod      (CFG_W'(TMOD)),
    .cfg_tzq       (CFG_W'(TZQ)),
    .pd_req        (pd_req),
    .cke           (cke),
    .pd_grant      (pd_grant),
    .pd_active     (pd_active)
  );

  function automatic int ref_wait(input int code, input bit bc4);
    int burst;
    burst = bc4 ? 2 : 4;
    case (code)
      1, 2, 3, 8: return 1;
      4, 5:       return RL + 5;
      6:          return WL + burst + WRC;
      7:          return WL + burst + WRC + 1;
      9:          return TMOD;
      10:         return TZQ;
      default:    return 0;
    endcase
  endfunction

  // reference model, advanced on every rising edge
  always @(posedge clk) begin
    if (rst) begin
      m_earliest = 0;
      m_open     = '0;
      m_cke      = 1'b1;
      m_grant    = 1'b0;
      m_act      = 1'b0;
    end else begin
      m_grant = 1'b0;
      if (m_cke) begin
        if (cmd_valid) begin
          if (cyc + ref_wait(int'(cmd_code), cmd_bc4) > m_earliest)
            m_earliest = cyc + ref_wait(int'(cmd_code), cmd_bc4);
          case (cmd_code)
            4'd1:             m_open[cmd_bank] = 1'b1;
            4'd2, 4'd5, 4'd7: m_open[cmd_bank] = 1'b0;
            4'd3:             m_open = '0;
            default: ;
          endcase
        end else if (pd_req && (cyc + 1 >= m_earliest)) begin
          m_cke   = 1'b0;
          m_grant = 1'b1;
          m_act   = (m_open != 0);
        end
      end else if (!pd_req) begin
        m_cke = 1'b1;
      end
    end
    cyc = cyc + 1;
  end

  // per-cycle comparison against the model
  always @(negedge clk) begin
    if (!rst && !done) begin
      checks++;
      if (cke !== m_cke || pd_grant !== m_grant || pd_active !== m_act) begin
        errors++;
        $display("FAIL %s cycle %0d: got cke/grant/active %b%b%b expected %b%b%b",
                 cur_req, cyc, cke, pd_grant, pd_active, m_cke, m_grant, m_act);
      end
    end
  end

  task automatic check(input bit ok, input string tag, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s: actual %0d expected %0d", tag, act, exp);
    end
  endtask

  task automatic issue(input int code, input int bank, input bit bc4, output int t);
    @(negedge clk);
    cmd_valid = 1'b1;
    cmd_code  = 4'(code);
    cmd_bank  = BANK_W'(bank);
    cmd_bc4   = bc4;
    t = cyc;
    @(negedge clk);
    cmd_valid = 1'b0;
  endtask

  // raise the request now and return the first low cke cycle
  task automatic enter(output int low_at);
    int n;
    pd_req = 1'b1;
    n = 0;
    while (cke && n < 400) begin
      @(negedge clk);
      n++;
    end
    low_at = cyc;
  endtask

  task automatic leave();
    pd_req = 1'b0;
    repeat (3) @(negedge clk);
  endtask

  task automatic measure(input int t, input int w, input int exp_act, input string tag);
    int low_at;
    int exp_at;
    exp_at = t + ((w > 2) ? w : 2);
    enter(low_at);
    check(low_at == exp_at, tag, low_at - t, exp_at - t);
    check(pd_grant == 1'b1, {tag, " grant"}, int'(pd_grant), 1);
    check(int'(pd_active) == exp_act, {tag, " kind"}, int'(pd_active), exp_act);
    leave();
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      done = 1'b1;
      errors++;
      $display("FAIL watchdog: actual hung expected finish");
      $display("  CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    int t, t2, low_at, kind0;
    repeat (3) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);

    cur_req = "R1";
    check(cke == 1'b1, "R1 cke", int'(cke), 1);
    check(pd_grant == 1'b0, "R1 grant", int'(pd_grant), 0);
    check(pd_active == 1'b0, "R1 kind", int'(pd_active), 0);

    cur_req = "R3";
    issue(1, 2, 0, t);  measure(t, 1, 1, "R3 act / R9 open");
    issue(2, 2, 0, t);  measure(t, 1, 0, "R3 pre / R9 closed");
    issue(8, 0, 0, t);  measure(t, 1, 0, "R3 refresh");

    cur_req = "R4";
    issue(4, 0, 0, t);  measure(t, RL + 5, 0, "R4 read");

    cur_req = "R5";
    issue(6, 0, 0, t);  measure(t, WL + 4 + WRC, 0, "R5 write bl8");
    issue(6, 0, 1, t);  measure(t, WL + 2 + WRC, 0, "R5 write bc4 fixed");

    cur_req = "R6";
    issue(7, 0, 0, t);  measure(t, WL + 4 + WRC + 1, 0, "R6 write ap");
    issue(7, 0, 1, t);  measure(t, WL + 2 + WRC + 1, 0, "R6 write ap bc4 fixed");

    cur_req = "R7";
    issue(9, 0, 0, t);  measure(t, TMOD, 0, "R7 mode set");
    issue(10, 0, 0, t); measure(t, TZQ, 0, "R7 zq cal");

    cur_req = "R9";
    issue(1, 1, 0, t);
    issue(5, 1, 0, t);  measure(t, RL + 5, 0, "R9 read ap closes / R4");

    cur_req = "R8";
    issue(6, 0, 0, t);
    issue(1, 3, 0, t2);
    measure(t, WL + 4 + WRC, 1, "R8 long wait kept");

    cur_req = "R9";
    issue(3, 0, 0, t);  measure(t, 1, 0, "R9 precharge all");

    cur_req = "R10";
    issue(1, 4, 0, t);
    enter(low_at);
    kind0 = int'(pd_active);
    check(kind0 == 1, "R10 kind at entry", kind0, 1);
    for (int i = 0; i < 10; i++) begin
      @(negedge clk);
      check(cke == 1'b0, "R10 cke held", int'(cke), 0);
      check(int'(pd_active) == kind0, "R10 kind held", int'(pd_active), kind0);
    end
    pd_req = 1'b0;
    @(negedge clk);
    check(cke == 1'b1, "R10 exit", int'(cke), 1);
    repeat (2) @(negedge clk);
    issue(2, 4, 0, t);
    repeat (2) @(negedge clk);

    cur_req = "R11";
    enter(low_at);
    @(negedge clk);
    cmd_valid = 1'b1; cmd_code = 4'd1; cmd_bank = 3'd5;
    @(negedge clk);
    cmd_code = 4'd9;
    @(negedge clk);
    cmd_valid = 1'b0;
    leave();
    enter(low_at);
    check(pd_active == 1'b0, "R11 no bank opened", int'(pd_active), 0);
    leave();
    t = cyc;
    enter(low_at);
    check(low_at == t + 1, "R11 no wait started", low_at - t, 1);
    leave();

    cur_req = "R12";
    issue(11, 6, 0, t); measure(t, 0, 0, "R12 code 11");
    issue(0, 6, 0, t);  measure(t, 0, 0, "R12 code 0");

    cur_req = "R2";
    @(negedge clk);
    pd_req = 1'b1;
    for (int i = 0; i < 5; i++) begin
      cmd_valid = 1'b1; cmd_code = 4'd0;
      t = cyc;
      @(negedge clk);
      check(cke == 1'b1, "R2 blocked by command", int'(cke), 1);
    end
    cmd_valid = 1'b0;
    enter(low_at);
    check(low_at == t + 2, "R2 entry after commands stop", low_at - t, 2);
    @(negedge clk);
    check(pd_grant == 1'b0, "R2 grant single cycle", int'(pd_grant), 0);
    leave();

    done = 1'b1;
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

endmodule